// File: doc/BRIEF.md
# Paged Multiplexed External Bus Sequencer

This block runs external memory cycles (instruction fetches, data reads and data writes) over a narrow pin set. One byte-wide address port carries the upper address byte during a latch phase and the lower byte at all other times. An external transparent latch captures the upper byte while the latch-enable output is high. A separate byte-wide data path carries only data. It is split into an input, an output and an output-enable, so the pad ring can build the tristate.

The sequencer remembers the upper address byte of the last external access. A request that stays in that page is a hit and skips the latch phase. A request that leaves the page, or that comes first after reset, is a miss and runs a latch phase before the transfer phase. A two-bit speed setting selects the phase length.

The core issues a request only while no cycle is running. It then waits for the one-clock completion pulse, which comes with the returned byte.

Top module: `pagebus_ctrl`

## Requirements
- R1: An accepted request is a miss if no request has been accepted since reset or if its address bits [15:8] differ from those of the previously accepted request. Any other request is a hit, unless R6 applies.
- R2: The speed setting gives a phase length H of 1 clock for 00, 2 clocks for 01, and 4 clocks for 10 and 11. A hit runs one transfer phase of H clocks. A miss runs a latch phase of H clocks and then a transfer phase of H clocks. `done` is high for exactly the one clock that follows the transfer phase.
- R3: Through the whole latch phase, `ale` is high, `adr_port` shows address bits [15:8], `psen_n`, `rd_n` and `wr_n` are high, and `dat_oe` is low.
- R4: Through the whole transfer phase, `ale` is low and `adr_port` shows address bits [7:0]. Exactly one strobe is low, chosen by `req_kind`: 0 is a fetch and drives `psen_n`, 1 is a data read and drives `rd_n`, 2 is a data write and drives `wr_n`. `dat_oe` is high, with `dat_out` equal to the write byte, during the write strobe and at no other time.
- R5: For a fetch or a read, the byte on `dat_in` is captured at the clock edge where the strobe returns high. It is presented on `rdata` while `done` is high.
- R6: With speed setting 00, every data read and every data write is a miss. A fetch whose preceding accepted request was a data read or write is also a miss.
- R7: The speed setting is sampled only when a request is accepted. Changing it during a cycle leaves that cycle's phase lengths unchanged.
- R8: A request presented while a cycle is in progress is ignored. A request with `req_kind` 3 is ignored. An ignored request starts no cycle and does not change the stored page.
- R9: After reset, `ale`, `dat_oe` and `done` are low, all strobes are high, and `adr_port` is 0. Between cycles, `adr_port` keeps the low byte of the last access.
- R10: Every accepted request stores its upper address byte, so a request that follows a miss and stays in the new page is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed | input | 2 | Phase length setting |
| req_valid | input | 1 | Request strobe, honoured only while idle |
| req_kind | input | 2 | 0 fetch, 1 data read, 2 data write, 3 ignored |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| rdata | output | 8 | Returned byte, valid with done |
| done | output | 1 | One-clock completion pulse |
| adr_port | output | 8 | Multiplexed address byte |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| dat_out | output | 8 | Data port output value |
| dat_oe | output | 1 | Data port output enable |
| dat_in | input | 8 | Data port input value |

## Verification
The bench aims at the page boundary. It checks the first access after reset and checks a request that follows an ignored kind-3 request. A design that forgets to clear its page-valid state, or that stores the page of an ignored request, shows a transfer phase where a latch phase belongs, or the reverse. It also covers the speed-00 rules, where a data move, and the fetch right after it, must each pay a latch phase even within the same page. It changes the speed setting and presents a stray request in the middle of a cycle. A design that samples the setting continuously would stretch or shorten that cycle, and one that accepts requests while busy would corrupt the address port. Reads go through a modelled external latch, so a wrongly classified hit returns the byte from the wrong page.

// File: rtl/pagebus_ctrl.sv
module pagebus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        speed,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W/2-1:0] adr_port,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] dat_out,
  output logic              dat_oe,
  input  logic [DATA_W-1:0] dat_in
);
  localparam int HALF = ADDR_W / 2;
  localparam logic [1:0] K_FETCH = 2'd0;
  localparam logic [1:0] K_READ  = 2'd1;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam logic [1:0] K_NONE  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_LATCH, S_XFER} st_t;

  st_t             st;
  logic [1:0]      cnt, len_q, kind_q, sel_len;
  logic [HALF-1:0] lo_q, page_q, req_hi, req_lo;
  logic            page_ok, last_data;
  logic            accept, is_data, miss;

  assign req_hi  = req_addr[ADDR_W-1:HALF];
  assign req_lo  = req_addr[HALF-1:0];
  assign is_data = req_kind != K_FETCH;
  assign accept  = (st == S_IDLE) && req_valid && (req_kind != K_NONE);
  assign miss    = !page_ok || (req_hi != page_q) ||
                   ((speed == 2'b00) && (is_data || last_data));
  assign sel_len = (speed == 2'b00) ? 2'd0 : (speed == 2'b01) ? 2'd1 : 2'd3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      len_q     <= '0;
      kind_q    <= K_FETCH;
      lo_q      <= '0;
      page_q    <= '0;
      page_ok   <= 1'b0;
      last_data <= 1'b0;
      adr_port  <= '0;
      ale       <= 1'b0;
      psen_n    <= 1'b1;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      dat_oe    <= 1'b0;
      dat_out   <= '0;
      rdata     <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          kind_q    <= req_kind;
          lo_q      <= req_lo;
          len_q     <= sel_len;
          cnt       <= sel_len;
          page_q    <= req_hi;
          page_ok   <= 1'b1;
          last_data <= is_data;
          dat_out   <= req_wdata;
          if (miss) begin
            st       <= S_LATCH;
            ale      <= 1'b1;
            adr_port <= req_hi;
          end else begin
            st       <= S_XFER;
            adr_port <= req_lo;
            psen_n   <= req_kind != K_FETCH;
            rd_n     <= req_kind != K_READ;
            wr_n     <= req_kind != K_WRITE;
            dat_oe   <= req_kind == K_WRITE;
          end
        end
        S_LATCH: if (cnt == 2'd0) begin
          st       <= S_XFER;
          cnt      <= len_q;
          ale      <= 1'b0;
          adr_port <= lo_q;
          psen_n   <= kind_q != K_FETCH;
          rd_n     <= kind_q != K_READ;
          wr_n     <= kind_q != K_WRITE;
          dat_oe   <= kind_q == K_WRITE;
        end else begin
          cnt <= cnt - 2'd1;
        end
        S_XFER: if (cnt == 2'd0) begin
          st     <= S_IDLE;
          psen_n <= 1'b1;
          rd_n   <= 1'b1;
          wr_n   <= 1'b1;
          dat_oe <= 1'b0;
          done   <= 1'b1;
          if (kind_q != K_WRITE) rdata <= dat_in;
        end else begin
          cnt <= cnt - 2'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pagebus_ctrl_chk.sv
module pagebus_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ale,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       dat_oe,
  input logic       done
);
  // R4
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  // R3
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n && !dat_oe));
  // R4
  drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> !wr_n);
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!ale && psen_n && rd_n && wr_n && !$past(psen_n && rd_n && wr_n)));
endmodule

bind pagebus_ctrl pagebus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
  .wr_n(wr_n), .dat_oe(dat_oe), .done(done)
);

// File: tb/pagebus_ctrl_test.sv
`timescale 1ns/1ps
module pagebus_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] speed = 2'b01;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic [7:0] rdata, adr_port, dat_out, dat_in;
  logic done, ale, psen_n, rd_n, wr_n, dat_oe;

  always #10 clk = ~clk;

  pagebus_ctrl uut (.clk(clk), .rst_n(rst_n), .speed(speed), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata),
    .done(done), .adr_port(adr_port), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .dat_out(dat_out), .dat_oe(dat_oe), .dat_in(dat_in));

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[15:8] ^ {a[3:0], a[7:4]} ^ 8'hA5;
  endfunction

  logic [7:0] ext_hi = 0;
  logic [15:0] wr_addr = 0;
  logic [7:0] wr_byte = 0;
  always @(negedge clk) begin
    if (ale) ext_hi = adr_port;
    if (!wr_n) begin wr_addr = {ext_hi, adr_port}; wr_byte = dat_out; end
  end
  assign dat_in = mem_f({ext_hi, adr_port});

  typedef struct {
    logic ale; logic [7:0] port; logic psn, rdn, wrn, oe;
    logic [7:0] dout; logic done, chk_rd; logic [7:0] rd;
  } ent_t;
  ent_t q[$];

  int vectors = 0, miscompares = 0;
  bit running = 0, finished = 0;
  bit m_ok = 0, m_last_data = 0;
  logic [7:0] m_page = 0, m_port = 0;

  task automatic report(string req, string what, int act, int exp);
    miscompares++;
    $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
  endtask

  task automatic step_check();
    ent_t e;
    if (q.size() > 0) e = q.pop_front();
    else e = '{ale:0, port:m_port, psn:1, rdn:1, wrn:1, oe:0, dout:0, done:0, chk_rd:0, rd:0};
    vectors++;
    if (ale !== e.ale) report("R3", "ale", ale, e.ale);
    if (adr_port !== e.port) report(e.ale ? "R3" : "R4", "adr_port", adr_port, e.port);
    if (psen_n !== e.psn) report("R4", "psen_n", psen_n, e.psn);
    if (rd_n !== e.rdn) report("R4", "rd_n", rd_n, e.rdn);
    if (wr_n !== e.wrn) report("R4", "wr_n", wr_n, e.wrn);
    if (dat_oe !== e.oe) report("R4", "dat_oe", dat_oe, e.oe);
    if (e.oe && dat_out !== e.dout) report("R4", "dat_out", dat_out, e.dout);
    if (done !== e.done) report("R2", "done", done, e.done);
    if (e.chk_rd && rdata !== e.rd) report("R5", "rdata", rdata, e.rd);
  endtask

  initial forever begin
    @(posedge clk); #3;
    if (running) step_check();
  end

  // issue one request; poke=1 disturbs speed and presents a stray request mid-cycle (R7, R8)
  task automatic issue(input logic [1:0] kind, input logic [15:0] addr,
                       input logic [7:0] wd, input bit poke, input logic [1:0] new_speed);
    int h; bit miss; ent_t e;
    if (kind != 2'd3) begin
      h = (speed == 2'b00) ? 1 : (speed == 2'b01) ? 2 : 4;
      miss = !m_ok || (addr[15:8] != m_page) ||
             (speed == 2'b00 && (kind != 0 || m_last_data));
      if (miss)
        for (int i = 0; i < h; i++) begin
          e = '{ale:1, port:addr[15:8], psn:1, rdn:1, wrn:1, oe:0, dout:0, done:0, chk_rd:0, rd:0};
          q.push_back(e);
        end
      for (int i = 0; i < h; i++) begin
        e = '{ale:0, port:addr[7:0], psn:(kind != 0), rdn:(kind != 1), wrn:(kind != 2),
              oe:(kind == 2), dout:wd, done:0, chk_rd:0, rd:0};
        q.push_back(e);
      end
      e = '{ale:0, port:addr[7:0], psn:1, rdn:1, wrn:1, oe:0, dout:0, done:1,
            chk_rd:(kind != 2), rd:mem_f(addr)};
      q.push_back(e);
      m_ok = 1; m_page = addr[15:8]; m_last_data = (kind != 0); m_port = addr[7:0];
    end
    req_valid = 1; req_kind = kind; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (poke) begin
      speed = new_speed;
      req_valid = 1; req_kind = 2'd2; req_addr = 16'h77C3; req_wdata = 8'hEE;
      @(negedge clk);
      req_valid = 0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    if (kind == 2'd2) begin
      vectors++;
      if (wr_addr !== addr || wr_byte !== wd)
        report("R4", "write addr/byte", {wr_addr, wr_byte}, {addr, wd});
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    report("WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++; // R9 reset state
    if (ale !== 0 || psen_n !== 1 || rd_n !== 1 || wr_n !== 1 || dat_oe !== 0 ||
        done !== 0 || adr_port !== 0)
      report("R9", "reset outputs", {ale, psen_n, rd_n, wr_n, dat_oe, done}, 6'b011100);
    rst_n = 1;
    @(negedge clk);
    running = 1;
    @(negedge clk);
    // R1 first access misses, then hits in the same page; R4 kinds
    issue(0, 16'h1234, 0, 0, 0);
    issue(0, 16'h1235, 0, 0, 0);
    issue(1, 16'h12F0, 0, 0, 0);
    issue(2, 16'h1201, 8'h3C, 0, 0);
    // R10 new page stored, then hit
    issue(0, 16'h3400, 0, 0, 0);
    issue(0, 16'h3401, 0, 0, 0);
    // R2 longer phases
    speed = 2'b10;
    issue(0, 16'h3402, 0, 0, 0);
    issue(1, 16'h5500, 0, 0, 0);
    speed = 2'b11;
    issue(2, 16'h5501, 8'h81, 0, 0);
    // R6 speed 00 forced misses
    speed = 2'b00;
    issue(0, 16'h5502, 0, 0, 0);
    issue(1, 16'h5503, 0, 0, 0);
    issue(0, 16'h5504, 0, 0, 0);
    issue(0, 16'h5505, 0, 0, 0);
    issue(2, 16'h5506, 8'h5F, 0, 0);
    issue(0, 16'h5507, 0, 0, 0);
    issue(0, 16'h5508, 0, 0, 0);
    // R8 kind 3 ignored, page unchanged
    issue(3, 16'h9999, 0, 0, 0);
    issue(0, 16'h5509, 0, 0, 0);
    // R7 and R8: speed change and stray request mid-cycle
    speed = 2'b01;
    issue(1, 16'h550A, 0, 1, 2'b10);
    issue(0, 16'h550B, 0, 0, 0);
    issue(0, 16'h66FE, 0, 1, 2'b00);
    issue(0, 16'h66FF, 0, 0, 0);
    // mixed patterns
    for (int i = 0; i < 24; i++) begin
      speed = i[1:0];
      issue(2'(i % 3), {6'h0A, i[4:3], 8'(i * 37)}, 8'(i * 11 + 1), 0, 0);
    end
    running = 0;
    finish_run();
  end
endmodule